// File: doc/BRIEF.md
# Banked Memory Mapper with Latched Time-of-Day Clock

This block sits between a processor's write bus and a cartridge's ROM and RAM. It decodes writes by the three top address bits. It keeps a 7-bit ROM bank number, a RAM bank number and a RAM access enable. It also keeps a mode flag that redirects the external RAM window to one of five clock registers.

The block holds a live time counter for seconds, minutes, hours and a 9-bit day count. The counter advances once for each pulse on a one-second tick input. Software reads the time from a frozen snapshot, not from the live counter. A two-step command (write 0, then write 1) to the latch region takes that snapshot. Software writes to a selected clock register go straight into the live counter. A halt bit stops the counting, and a sticky overflow bit records that the day count wrapped.

Top module: `rtc_bank_mapper`

## Requirements
- R1: A write to region 0 (address bits [15:13] = 0) with data 0x0A sets `xram_en`, and with data 0x00 clears it. Any other data leaves it unchanged. After reset it is 0.
- R2: A write to region 1 sets `rom_bank` to data bits [6:0], but a value of zero in those bits gives 1. Bit 7 is ignored. After reset `rom_bank` is 1.
- R3: A write to region 2 with data 0 to 3 sets `ram_bank` to that value and clears `clock_mode`.
- R4: A write to region 2 with data 0x08 to 0x0C sets `clock_idx` to data minus 8 and sets `clock_mode`. The other values (0x04 to 0x07, and 0x0D and above) change nothing.
- R5: A write to region 3 with data 1 while the snapshot is not held copies the live counter into the snapshot and marks it held. Data 0 while held clears the held mark. Every other region-3 write, including a second 1 while held, has no effect.
- R6: Each tick advances seconds modulo 60, with a carry into minutes. Minutes count modulo 60, with a carry into hours. Hours count modulo 24, with a carry into the day count.
- R7: The day count is 9 bits. Clock register 3 holds day bits [7:0]. Clock register 4 holds day bit 8 in bit 0.
- R8: A carry out of day 511 wraps the day to 0 and sets bit 7 of register 4. That bit stays set until software writes register 4 with bit 7 clear.
- R9: Bit 6 of register 4 is a halt flag. While it is set, ticks are ignored.
- R10: A write to region 5 (0xA000 to 0xBFFF) while `xram_en` and `clock_mode` are both set loads the live field selected by `clock_idx`. Register 0 is seconds in bits [5:0], register 1 is minutes in bits [5:0], and register 2 is hours in bits [4:0]. Such a write overrides a tick in the same cycle. The same write is ignored when either flag is clear.
- R11: While `xram_en` and `clock_mode` are both set, `clock_rdata` shows the snapshot of the selected register, with unused bits reading zero. Otherwise it reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Write address |
| bus_wdata | input | 8 | Write data |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| rom_bank | output | 7 | Selected switchable ROM bank |
| ram_bank | output | 2 | Selected RAM bank |
| xram_en | output | 1 | External RAM / clock access enabled |
| clock_mode | output | 1 | RAM window mapped to a clock register |
| clock_idx | output | 3 | Selected clock register (0 to 4) |
| clock_rdata | output | 8 | Read data of the selected snapshot register |

## Verification
The hardest case to reach from the ports is a carry that ripples through all four fields into the day overflow. With ticks alone that would take 512 days of pulses. The bench instead loads 59 s, 59 min, 23 h and day 511 through region-5 writes, then sends one tick. It takes a snapshot and reads every register back. It also drives a tick and a register write in the same cycle. It checks that a second latch command while the snapshot is held leaves the snapshot frozen.

// File: rtl/rtcmap_pkg.sv
package rtcmap_pkg;

    localparam int SEC_W        = 6;
    localparam int MIN_W        = 6;
    localparam int HOUR_W       = 5;
    localparam int DAY_W        = 9;
    localparam int CLK_REG_CNT  = 5;
    localparam int CLK_IDX_W    = $clog2(CLK_REG_CNT);
    localparam logic [7:0] CLK_SEL_BASE = 8'h08;
    localparam logic [7:0] EN_KEY       = 8'h0A;

    localparam logic [2:0] RGN_ENABLE = 3'd0;
    localparam logic [2:0] RGN_ROM    = 3'd1;
    localparam logic [2:0] RGN_RAMSEL = 3'd2;
    localparam logic [2:0] RGN_LATCH  = 3'd3;
    localparam logic [2:0] RGN_XRAM   = 3'd5;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [DAY_W-1:0]  day;
        logic              halt;
        logic              ovf;
    } clk_time_t;

endpackage

// File: rtl/bank_select_regs.sv
module bank_select_regs
    import rtcmap_pkg::*;
#(
    parameter int ROM_W = 7,
    parameter int RAM_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           region,
    input  logic [7:0]           wdata,
    output logic [ROM_W-1:0]     rom_bank,
    output logic [RAM_W-1:0]     ram_bank,
    output logic                 acc_en,
    output logic                 clk_mode,
    output logic [CLK_IDX_W-1:0] clk_idx
);

    localparam logic [7:0] RAM_BANKS = 8'(1 << RAM_W);
    localparam logic [7:0] SEL_LAST  = CLK_SEL_BASE + 8'(CLK_REG_CNT - 1);

    typedef struct packed {
        logic [ROM_W-1:0]     rom;
        logic [RAM_W-1:0]     ram;
        logic                 en;
        logic                 mode;
        logic [CLK_IDX_W-1:0] idx;
    } sel_state_t;

    sel_state_t st_d, st_q;
    logic [7:0] idx_raw;

    always_comb begin
        st_d    = st_q;
        idx_raw = wdata - CLK_SEL_BASE;
        if (wr_en) begin
            case (region)
                RGN_ENABLE: begin
                    if (wdata == EN_KEY)     st_d.en = 1'b1;
                    else if (wdata == 8'h00) st_d.en = 1'b0;
                end
                RGN_ROM: begin
                    if (wdata[ROM_W-1:0] == '0) st_d.rom = ROM_W'(1);
                    else                        st_d.rom = wdata[ROM_W-1:0];
                end
                RGN_RAMSEL: begin
                    if (wdata < RAM_BANKS) begin
                        st_d.ram  = wdata[RAM_W-1:0];
                        st_d.mode = 1'b0;
                    end else if (wdata >= CLK_SEL_BASE && wdata <= SEL_LAST) begin
                        st_d.idx  = idx_raw[CLK_IDX_W-1:0];
                        st_d.mode = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rom <= ROM_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_bank = st_q.rom;
    assign ram_bank = st_q.ram;
    assign acc_en   = st_q.en;
    assign clk_mode = st_q.mode;
    assign clk_idx  = st_q.idx;

    assert_enable_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RGN_ENABLE && wdata == EN_KEY) |=> acc_en);

    assert_rom_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RGN_ROM && wdata[ROM_W-1:0] == '0) |=> rom_bank == ROM_W'(1));

    assert_ram_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RGN_RAMSEL && wdata < RAM_BANKS)
        |=> (!clk_mode && ram_bank == $past(wdata[RAM_W-1:0])));

    assert_bad_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RGN_RAMSEL && wdata >= RAM_BANKS && wdata < CLK_SEL_BASE)
        |=> ($stable(clk_mode) && $stable(clk_idx) && $stable(ram_bank)));

endmodule

// File: rtl/live_time_counter.sv
module live_time_counter
    import rtcmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 ld_en,
    input  logic [CLK_IDX_W-1:0] ld_idx,
    input  logic [7:0]           ld_data,
    output clk_time_t            live
);

    localparam logic [SEC_W-1:0]  SEC_TOP  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_TOP  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_TOP = HOUR_W'(23);
    localparam logic [DAY_W-1:0]  DAY_TOP  = '1;

    clk_time_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ld_en) begin
            case (ld_idx)
                CLK_IDX_W'(0): t_d.sec      = ld_data[SEC_W-1:0];
                CLK_IDX_W'(1): t_d.min      = ld_data[MIN_W-1:0];
                CLK_IDX_W'(2): t_d.hour     = ld_data[HOUR_W-1:0];
                CLK_IDX_W'(3): t_d.day[7:0] = ld_data;
                CLK_IDX_W'(4): begin
                    t_d.day[8] = ld_data[0];
                    t_d.halt   = ld_data[6];
                    t_d.ovf    = ld_data[7];
                end
                default: ;
            endcase
        end else if (tick && !t_q.halt) begin
            if (t_q.sec < SEC_TOP) begin
                t_d.sec = t_q.sec + 1'b1;
            end else begin
                t_d.sec = '0;
                if (t_q.min < MIN_TOP) begin
                    t_d.min = t_q.min + 1'b1;
                end else begin
                    t_d.min = '0;
                    if (t_q.hour < HOUR_TOP) begin
                        t_d.hour = t_q.hour + 1'b1;
                    end else begin
                        t_d.hour = '0;
                        if (t_q.day == DAY_TOP) begin
                            t_d.day = '0;
                            t_d.ovf = 1'b1;
                        end else begin
                            t_d.day = t_q.day + 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign live = t_q;

    assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !live.halt && live.sec == SEC_TOP)
        |=> (live.sec == '0 && live.min != $past(live.min)));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live.ovf && !(ld_en && ld_idx == CLK_IDX_W'(4))) |=> live.ovf);

    assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (live.halt && !ld_en) |=> $stable(live));

endmodule

// File: rtl/time_snapshot.sv
module time_snapshot
    import rtcmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [7:0]           cmd_data,
    input  clk_time_t            live,
    input  logic                 rd_active,
    input  logic [CLK_IDX_W-1:0] rd_idx,
    output logic [7:0]           rd_data
);

    typedef struct packed {
        clk_time_t snap;
        logic      held;
    } snap_state_t;

    snap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cmd_wr) begin
            if (s_q.held && cmd_data == 8'h00) begin
                s_d.held = 1'b0;
            end else if (!s_q.held && cmd_data == 8'h01) begin
                s_d.snap = live;
                s_d.held = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_active) begin
            case (rd_idx)
                CLK_IDX_W'(0): rd_data = 8'(s_q.snap.sec);
                CLK_IDX_W'(1): rd_data = 8'(s_q.snap.min);
                CLK_IDX_W'(2): rd_data = 8'(s_q.snap.hour);
                CLK_IDX_W'(3): rd_data = s_q.snap.day[7:0];
                CLK_IDX_W'(4): rd_data = {s_q.snap.ovf, s_q.snap.halt, 5'b0, s_q.snap.day[8]};
                default:       rd_data = 8'h00;
            endcase
        end
    end

    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(s_q.snap));

    assert_relatch_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && s_q.held) |=> $stable(s_q.snap));

endmodule

// File: rtl/rtc_bank_mapper.sv
module rtc_bank_mapper
    import rtcmap_pkg::*;
#(
    parameter int ROM_W  = 7,
    parameter int RAM_W  = 2,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    input  logic                 sec_tick,
    output logic [ROM_W-1:0]     rom_bank,
    output logic [RAM_W-1:0]     ram_bank,
    output logic                 xram_en,
    output logic                 clock_mode,
    output logic [CLK_IDX_W-1:0] clock_idx,
    output logic [7:0]           clock_rdata
);

    logic [2:0]        region;
    logic [ADDR_W-4:0] unused_low_addr;
    logic              win_active;
    logic              field_ld;
    logic              latch_cmd;
    clk_time_t         live;

    assign region          = bus_addr[ADDR_W-1:ADDR_W-3];
    assign unused_low_addr = bus_addr[ADDR_W-4:0];
    assign win_active      = xram_en && clock_mode;
    assign field_ld        = bus_we && region == RGN_XRAM && win_active;
    assign latch_cmd       = bus_we && region == RGN_LATCH;

    bank_select_regs #(.ROM_W(ROM_W), .RAM_W(RAM_W)) sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .region   (region),
        .wdata    (bus_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .acc_en   (xram_en),
        .clk_mode (clock_mode),
        .clk_idx  (clock_idx)
    );

    live_time_counter cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .ld_en   (field_ld),
        .ld_idx  (clock_idx),
        .ld_data (bus_wdata),
        .live    (live)
    );

    time_snapshot snap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (latch_cmd),
        .cmd_data  (bus_wdata),
        .live      (live),
        .rd_active (win_active),
        .rd_idx    (clock_idx),
        .rd_data   (clock_rdata)
    );

    assert_ld_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && region == RGN_XRAM && !win_active && !sec_tick) |=> $stable(live));

    assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |-> clock_rdata == 8'h00);

endmodule

// File: tb/rtc_bank_mapper_tb_top.sv
module rtc_bank_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        sec_tick = 1'b0;
    logic [6:0]  rom_bank;
    logic [1:0]  ram_bank;
    logic        xram_en;
    logic        clock_mode;
    logic [2:0]  clock_idx;
    logic [7:0]  clock_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    rtc_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sec_tick(sec_tick), .rom_bank(rom_bank),
        .ram_bank(ram_bank), .xram_en(xram_en), .clock_mode(clock_mode),
        .clock_idx(clock_idx), .clock_rdata(clock_rdata)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic [6:0]  rom;
        logic [1:0]  ram;
        logic        en;
        logic        mode;
        logic [2:0]  idx;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 8'h0A, 7'd1,    2'd0, 1'b1, 1'b0, 3'd0},
        '{16'h1FFF, 8'h05, 7'd1,    2'd0, 1'b1, 1'b0, 3'd0},
        '{16'h0000, 8'h00, 7'd1,    2'd0, 1'b0, 1'b0, 3'd0},
        '{16'h2000, 8'h00, 7'd1,    2'd0, 1'b0, 1'b0, 3'd0},
        '{16'h3000, 8'h7F, 7'h7F,   2'd0, 1'b0, 1'b0, 3'd0},
        '{16'h2000, 8'h85, 7'd5,    2'd0, 1'b0, 1'b0, 3'd0},
        '{16'h2000, 8'h80, 7'd1,    2'd0, 1'b0, 1'b0, 3'd0},
        '{16'h4000, 8'h03, 7'd1,    2'd3, 1'b0, 1'b0, 3'd0},
        '{16'h4000, 8'h0A, 7'd1,    2'd3, 1'b0, 1'b1, 3'd2},
        '{16'h4000, 8'h05, 7'd1,    2'd3, 1'b0, 1'b1, 3'd2},
        '{16'h5FFF, 8'h0D, 7'd1,    2'd3, 1'b0, 1'b1, 3'd2},
        '{16'h4000, 8'h0C, 7'd1,    2'd3, 1'b0, 1'b1, 3'd4},
        '{16'h4000, 8'h01, 7'd1,    2'd1, 1'b0, 1'b0, 3'd4},
        '{16'h4000, 8'h08, 7'd1,    2'd1, 1'b0, 1'b1, 3'd0},
        '{16'h6000, 8'h00, 7'd1,    2'd1, 1'b0, 1'b1, 3'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic set_reg(input logic [2:0] idx, input logic [7:0] d);
        wr(16'h4000, 8'h08 + 8'(idx));
        wr(16'hA000, d);
    endtask

    task automatic snap();
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
    endtask

    task automatic rd_chk(input string req, input logic [2:0] idx, input logic [7:0] exp);
        wr(16'h4000, 8'h08 + 8'(idx));
        chk(req, 32'(clock_rdata), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state R1 R2 R11
        chk("R2 reset rom", 32'(rom_bank), 32'd1);
        chk("R1 reset en", 32'(xram_en), 32'd0);
        chk("R3 reset ram", 32'(ram_bank), 32'd0);
        chk("R11 reset rdata", 32'(clock_rdata), 32'd0);

        // vector walk: R1 R2 R3 R4
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].addr, VECS[i].data);
            chk("R2 vec rom", 32'(rom_bank), 32'(VECS[i].rom));
            chk("R3 vec ram", 32'(ram_bank), 32'(VECS[i].ram));
            chk("R1 vec en", 32'(xram_en), 32'(VECS[i].en));
            chk("R4 vec mode", 32'(clock_mode), 32'(VECS[i].mode));
            chk("R4 vec idx", 32'(clock_idx), 32'(VECS[i].idx));
        end

        // R10: load ignored while access disabled (en=0, mode=1, idx=0)
        wr(16'hA000, 8'd33);
        chk("R11 disabled rdata", 32'(clock_rdata), 32'd0);
        wr(16'h0000, 8'h0A);
        snap();
        rd_chk("R10 ignored when disabled", 3'd0, 8'd0);

        // R6 seconds count, minute untouched
        set_reg(3'd0, 8'd58);
        set_reg(3'd1, 8'd5);
        tick_n(1);
        snap();
        rd_chk("R6 sec increment", 3'd0, 8'd59);
        rd_chk("R6 min unchanged", 3'd1, 8'd5);
        tick_n(1);
        snap();
        rd_chk("R6 sec wrap", 3'd0, 8'd0);
        rd_chk("R6 min carry", 3'd1, 8'd6);

        // R6 R7 R8 full ripple into day overflow
        set_reg(3'd0, 8'd59);
        set_reg(3'd1, 8'd59);
        set_reg(3'd2, 8'd23);
        set_reg(3'd3, 8'hFF);
        set_reg(3'd4, 8'h01);
        snap();
        rd_chk("R7 day low", 3'd3, 8'hFF);
        rd_chk("R7 day bit8", 3'd4, 8'h01);
        rd_chk("R10 hour load", 3'd2, 8'd23);
        tick_n(1);
        snap();
        rd_chk("R6 sec ripple", 3'd0, 8'd0);
        rd_chk("R6 min ripple", 3'd1, 8'd0);
        rd_chk("R6 hour ripple", 3'd2, 8'd0);
        rd_chk("R7 day wrap", 3'd3, 8'd0);
        rd_chk("R8 overflow set", 3'd4, 8'h80);
        tick_n(2);
        snap();
        rd_chk("R8 overflow sticky", 3'd4, 8'h80);
        rd_chk("R6 sec after overflow", 3'd0, 8'd2);

        // R9 halt, also clears overflow (R8)
        set_reg(3'd4, 8'h40);
        tick_n(3);
        snap();
        rd_chk("R9 halted sec", 3'd0, 8'd2);
        rd_chk("R8 overflow cleared", 3'd4, 8'h40);
        set_reg(3'd4, 8'h00);
        tick_n(1);
        snap();
        rd_chk("R9 resumed", 3'd0, 8'd3);

        // R5: second latch while held is ignored
        set_reg(3'd0, 8'd10);
        wr(16'h6000, 8'h01);
        rd_chk("R5 relatch blocked", 3'd0, 8'd3);
        wr(16'h6000, 8'h05);
        wr(16'h6000, 8'h01);
        rd_chk("R5 other data no release", 3'd0, 8'd3);
        snap();
        rd_chk("R5 relatch after release", 3'd0, 8'd10);

        // R10: write wins over same-cycle tick
        wr(16'h4000, 8'h08);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 16'hA000; bus_wdata = 8'd20; sec_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; sec_tick = 1'b0;
        snap();
        rd_chk("R10 write beats tick", 3'd0, 8'd20);

        // R10: ignored in RAM mode; R11 reads zero outside clock mode
        wr(16'h4000, 8'h02);
        chk("R11 ram mode rdata", 32'(clock_rdata), 32'd0);
        wr(16'hA000, 8'd44);
        snap();
        rd_chk("R10 ignored in ram mode", 3'd0, 8'd20);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule